// File: doc/BRIEF.md
# SMI Trigger with Feature Lock

This block sits behind a power-management command port. Each command byte written by a core is decoded in one of three ways. Two reserved values switch ACPI mode on or off by driving the SCI enable output. Any other value may raise a system-management interrupt (SMI), delivered as a one-cycle pulse on a per-core vector. Whether the SMI fires depends on an APM-command enable bit in an SMI enable register. Where it goes depends on a feature set that firmware negotiates once through a small register file. With broadcast negotiated, every core is pulsed. Without it, only the writing core is pulsed.

Negotiation is write-once. Software reads the host-supported mask and writes a requested mask. It then writes the accept register. A request that stays within the host mask is copied into the negotiated set and the accept flag rises. The set then stays frozen until reset. A separate lock bit in a PM configuration register is also sticky once set, and it makes the global SMI enable bit read-only.

Three small state machines hold the behaviour. The negotiator has states `NEG_OPEN` and `NEG_DONE`, with one transition `NEG_OPEN -> NEG_DONE` on an accept write whose request fits the host mask. The lock machine has states `LK_OPEN` and `LK_SET`, with one transition `LK_OPEN -> LK_SET` on a PM configuration write with the lock bit at 1. The command decoder has states `CMD_IDLE` and `CMD_PULSE`. It enters `CMD_PULSE` on any SMI-raising command and returns to `CMD_IDLE` on the next cycle without one. Only reset leaves `NEG_DONE` and `LK_SET`.

Top module: `smi_feature_gate`

## Requirements
- R1: After reset `sci_en` is 0, `smi_pulse` is all zero, the requested mask, accept flag, SMI enable register and PM configuration register all read 0, and SMIs go only to the writing core.
- R2: Command 0xE1 sets `sci_en` and command 0x1E clears it. Neither of these commands ever produces an SMI pulse.
- R3: Any other command produces an SMI only when bit 5 (APM-command enable) of the SMI enable register (address 5) is 1. Otherwise `smi_pulse` stays zero.
- R4: An SMI pulse appears in the cycle after the command write and lasts exactly one cycle.
- R5: Unless broadcast is negotiated, the pulse has only bit `cmd_core` set.
- R6: When bit 0 (broadcast) of the negotiated set is 1, the pulse has every core bit set.
- R7: The host mask reads at address 0 (bits 31:0) and address 1 (bits 63:32). Writes to these addresses are ignored.
- R8: The requested mask is read/write at address 2 (bits 31:0) and address 3 (bits 63:32).
- R9: A write to address 4 (accept) while not yet accepted checks the requested mask. If the mask holds any bit outside the host mask, the accept flag (read at address 4, bit 0) stays 0 and the negotiated set is unchanged. Otherwise the mask is copied into the negotiated set and the flag becomes 1.
- R10: Once the accept flag is 1, further accept writes are ignored and the negotiated set is kept, even after the requested mask changes.
- R11: Bit 4 of the PM configuration register (address 6) is the lock. Once it is written to 1 it reads 1 and cannot be cleared until reset.
- R12: While the lock is set, bit 0 (global SMI enable) of the SMI enable register ignores writes. Its other bits stay writable.
- R13: Reset clears the lock, the accept flag and the negotiated set, which makes the global enable writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_core | input | CORE_W | Index of the core performing the command write |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| sci_en | output | 1 | ACPI mode (SCI enable) |
| smi_pulse | output | NUM_CORES | One-cycle SMI per core |

## Verification
The hardest situation to reach is a frozen negotiation that then faces contradicting writes. The stimulus first drives two rejected accept attempts: one with an illegal low bit and one with an illegal high-word bit. A legal request follows, then the request is cleared and accepted again, and the bench shows that broadcast still holds. The lock is driven the same way. The global enable is set, the lock is set, and clearing either is attempted. A mid-run reset follows to show that both freezes are lifted and that delivery falls back to the single writing core.

// File: rtl/smi_feat_pkg.sv
package smi_feat_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_HOST_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_HOST_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_REQ_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_REQ_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ACCEPT  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_SMI_EN  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_PMCFG   = 3'd6;

    localparam int GBL_EN_BIT = 0;
    localparam int APMC_BIT   = 5;
    localparam int LOCK_BIT   = 4;
    localparam int BCAST_BIT  = 0;

    typedef enum logic { NEG_OPEN, NEG_DONE } neg_state_e;
    typedef enum logic { LK_OPEN, LK_SET } lock_state_e;
    typedef enum logic { CMD_IDLE, CMD_PULSE } cmd_state_e;

endpackage

// File: rtl/feat_negotiator.sv
module feat_negotiator
    import smi_feat_pkg::*;
#(
    parameter logic [63:0] HOST_MASK = 64'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [63:0]       req_q,
    output logic [63:0]       neg_q,
    output logic              feat_ok
);

    neg_state_e state_q, state_d;
    logic       accept_wr;
    logic       req_legal;

    assign accept_wr = wr_en && (wr_addr == ADR_ACCEPT);
    assign req_legal = ((req_q & ~HOST_MASK) == 64'h0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NEG_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEG_OPEN: if (accept_wr && req_legal) state_d = NEG_DONE;
            NEG_DONE: state_d = NEG_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 64'h0;
            neg_q <= 64'h0;
        end else begin
            if (wr_en && wr_addr == ADR_REQ_LO) req_q[31:0]  <= wr_data;
            if (wr_en && wr_addr == ADR_REQ_HI) req_q[63:32] <= wr_data;
            if (state_q == NEG_OPEN && accept_wr && req_legal) neg_q <= req_q;
        end
    end

    always_comb begin
        unique case (state_q)
            NEG_OPEN: feat_ok = 1'b0;
            NEG_DONE: feat_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_feat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       smi_en_q,
    output logic [15:0]       pmcfg_rd,
    output logic              locked
);

    lock_state_e state_q, state_d;
    logic [15:0] pmcfg_q;
    logic        pm_wr;
    logic        en_wr;

    assign pm_wr = wr_en && (wr_addr == ADR_PMCFG);
    assign en_wr = wr_en && (wr_addr == ADR_SMI_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (pm_wr && wr_data[LOCK_BIT]) state_d = LK_SET;
            LK_SET:  state_d = LK_SET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_en_q <= 32'h0;
            pmcfg_q  <= 16'h0;
        end else begin
            if (en_wr) begin
                smi_en_q <= wr_data;
                if (state_q == LK_SET) smi_en_q[GBL_EN_BIT] <= smi_en_q[GBL_EN_BIT];
            end
            if (pm_wr) begin
                pmcfg_q           <= wr_data[15:0];
                pmcfg_q[LOCK_BIT] <= 1'b0;
            end
        end
    end

    always_comb begin
        pmcfg_rd = pmcfg_q;
        unique case (state_q)
            LK_OPEN: locked = 1'b0;
            LK_SET:  locked = 1'b1;
        endcase
        pmcfg_rd[LOCK_BIT] = locked;
    end

endmodule

// File: rtl/apm_cmd_decoder.sv
module apm_cmd_decoder
    import smi_feat_pkg::*;
#(
    parameter int         NUM_CORES    = 4,
    parameter int         CORE_W       = 2,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0] ACPI_OFF_CMD = 8'h1E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_data,
    input  logic [CORE_W-1:0]    cmd_core,
    input  logic                 apmc_en,
    input  logic                 bcast,
    output logic                 sci_en,
    output logic [NUM_CORES-1:0] smi_pulse
);

    cmd_state_e           state_q, state_d;
    logic [NUM_CORES-1:0] target_q, target_d;
    logic [NUM_CORES-1:0] self_vec;
    logic                 is_on, is_off, fire;

    assign is_on  = cmd_valid && (cmd_data == ACPI_ON_CMD);
    assign is_off = cmd_valid && (cmd_data == ACPI_OFF_CMD);
    assign fire   = cmd_valid && !is_on && !is_off && apmc_en;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_self
        assign self_vec[g] = (cmd_core == CORE_W'(g));
    end

    assign target_d = bcast ? {NUM_CORES{1'b1}} : self_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CMD_IDLE;
            target_q <= '0;
            sci_en   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) target_q <= target_d;
            if (is_on) sci_en <= 1'b1;
            else if (is_off) sci_en <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:  if (fire) state_d = CMD_PULSE;
            CMD_PULSE: state_d = fire ? CMD_PULSE : CMD_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CMD_IDLE:  smi_pulse = '0;
            CMD_PULSE: smi_pulse = target_q;
        endcase
    end

endmodule

// File: rtl/smi_feature_gate.sv
module smi_feature_gate
    import smi_feat_pkg::*;
#(
    parameter int          NUM_CORES    = 4,
    parameter logic [63:0] HOST_MASK    = 64'h1,
    parameter logic [7:0]  ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0]  ACPI_OFF_CMD = 8'h1E,
    localparam int         CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_data,
    input  logic [CORE_W-1:0]    cmd_core,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [2:0]           rd_addr,
    output logic [31:0]          rd_data,
    output logic                 sci_en,
    output logic [NUM_CORES-1:0] smi_pulse
);

    logic [63:0] req_q, neg_q;
    logic        feat_ok;
    logic [31:0] smi_en_q;
    logic [15:0] pmcfg_rd;
    logic        locked;
    logic        neg_bcast;
    logic        gbl_en;

    assign neg_bcast = neg_q[BCAST_BIT];
    assign gbl_en    = smi_en_q[GBL_EN_BIT];

    feat_negotiator #(.HOST_MASK(HOST_MASK)) u_neg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req_q   (req_q),
        .neg_q   (neg_q),
        .feat_ok (feat_ok)
    );

    smi_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .smi_en_q (smi_en_q),
        .pmcfg_rd (pmcfg_rd),
        .locked   (locked)
    );

    apm_cmd_decoder #(
        .NUM_CORES    (NUM_CORES),
        .CORE_W       (CORE_W),
        .ACPI_ON_CMD  (ACPI_ON_CMD),
        .ACPI_OFF_CMD (ACPI_OFF_CMD)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_core  (cmd_core),
        .apmc_en   (smi_en_q[APMC_BIT]),
        .bcast     (neg_bcast),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse)
    );

    always_comb begin
        unique case (rd_addr)
            ADR_HOST_LO: rd_data = HOST_MASK[31:0];
            ADR_HOST_HI: rd_data = HOST_MASK[63:32];
            ADR_REQ_LO:  rd_data = req_q[31:0];
            ADR_REQ_HI:  rd_data = req_q[63:32];
            ADR_ACCEPT:  rd_data = {31'h0, feat_ok};
            ADR_SMI_EN:  rd_data = smi_en_q;
            ADR_PMCFG:   rd_data = {16'h0, pmcfg_rd};
            default:     rd_data = 32'h0;
        endcase
    end

endmodule

// File: rtl/smi_feature_gate_chk.sv
module smi_feature_gate_chk #(
    parameter int         NUM_CORES    = 4,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0] ACPI_OFF_CMD = 8'h1E
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [7:0]           cmd_data,
    input logic [NUM_CORES-1:0] smi_pulse,
    input logic                 sci_en,
    input logic                 neg_bcast,
    input logic                 feat_ok,
    input logic                 locked,
    input logic                 gbl_en
);

    assert_acpi_no_smi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_data == ACPI_ON_CMD || cmd_data == ACPI_OFF_CMD) |=> smi_pulse == '0);

    assert_sci_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_data == ACPI_ON_CMD |=> sci_en);

    assert_pulse_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse != '0 |-> $past(cmd_valid));

    assert_unicast_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse != '0 && !$past(neg_bcast) |-> $onehot(smi_pulse));

    assert_bcast_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse != '0 && $past(neg_bcast) |-> &smi_pulse);

    assert_ok_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |=> feat_ok && $stable(neg_bcast));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_gbl_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(gbl_en));

endmodule

bind smi_feature_gate smi_feature_gate_chk #(
    .NUM_CORES    (NUM_CORES),
    .ACPI_ON_CMD  (ACPI_ON_CMD),
    .ACPI_OFF_CMD (ACPI_OFF_CMD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .smi_pulse (smi_pulse),
    .sci_en    (sci_en),
    .neg_bcast (neg_bcast),
    .feat_ok   (feat_ok),
    .locked    (locked),
    .gbl_en    (gbl_en)
);

// File: tb/smi_feature_gate_test.sv
module smi_feature_gate_test;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_data = 8'h0;
    logic [1:0]    cmd_core = 2'd0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = 3'd0;
    logic [31:0]   wr_data = 32'h0;
    logic [2:0]    rd_addr = 3'd0;
    logic [31:0]   rd_data;
    logic          sci_en;
    logic [NC-1:0] smi_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [NC-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    smi_feature_gate #(.NUM_CORES(NC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_core  (cmd_core),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic send_cmd(logic [7:0] d, logic [1:0] core, logic [NC-1:0] exp, string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_data = d; cmd_core = core;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares pulse one cycle after each command, then checks it is gone.
    initial begin
        bit issued;
        bit prev_issued;
        prev_issued = 1'b0;
        forever begin
            @(posedge clk);
            issued = cmd_valid;
            @(negedge clk);
            if (issued) begin
                logic [NC-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(smi_pulse), 32'(e));
            end else if (prev_issued) begin
                check("R4 pulse width", 32'(smi_pulse), 32'h0);
            end
            prev_issued = issued;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 sci_en", 32'(sci_en), 32'h0);
        check("R1 smi_pulse", 32'(smi_pulse), 32'h0);
        rd_chk(3'd2, 32'h0, "R1 req lo");
        rd_chk(3'd4, 32'h0, "R1 accept");
        rd_chk(3'd5, 32'h0, "R1 smi_en");
        rd_chk(3'd6, 32'h0, "R1 pmcfg");

        // R7 host mask read-only
        rd_chk(3'd0, 32'h1, "R7 host lo");
        rd_chk(3'd1, 32'h0, "R7 host hi");
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h1, "R7 host lo after write");

        // R2 ACPI commands
        send_cmd(8'hE1, 2'd0, 4'b0000, "R2 on no smi");
        check("R2 sci set", 32'(sci_en), 32'h1);
        send_cmd(8'h1E, 2'd1, 4'b0000, "R2 off no smi");
        check("R2 sci clear", 32'(sci_en), 32'h0);

        // R3 gating
        send_cmd(8'h55, 2'd2, 4'b0000, "R3 gated off");
        wr(3'd5, 32'h20);
        send_cmd(8'h55, 2'd2, 4'b0100, "R3 R5 unicast core2");
        send_cmd(8'hB2, 2'd0, 4'b0001, "R5 unicast core0");
        // R2 with enable set
        send_cmd(8'hE1, 2'd3, 4'b0000, "R2 on no smi with enable");
        check("R2 sci set again", 32'(sci_en), 32'h1);

        // R8 / R9 rejected requests
        wr(3'd2, 32'h2);
        rd_chk(3'd2, 32'h2, "R8 req lo");
        wr(3'd4, 32'h1);
        rd_chk(3'd4, 32'h0, "R9 illegal low bit rejected");
        send_cmd(8'h55, 2'd1, 4'b0010, "R9 still unicast");
        wr(3'd2, 32'h1);
        wr(3'd3, 32'h8000_0000);
        rd_chk(3'd3, 32'h8000_0000, "R8 req hi");
        wr(3'd4, 32'h1);
        rd_chk(3'd4, 32'h0, "R9 illegal high bit rejected");

        // R9 legal, R6 broadcast
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        rd_chk(3'd4, 32'h1, "R9 accepted");
        send_cmd(8'h55, 2'd3, 4'b1111, "R6 broadcast");

        // R10 frozen
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h1);
        rd_chk(3'd4, 32'h1, "R10 accept stays");
        send_cmd(8'h77, 2'd0, 4'b1111, "R10 broadcast kept");

        // R11 / R12 lock
        wr(3'd5, 32'h21);
        rd_chk(3'd5, 32'h21, "R12 gbl writable before lock");
        wr(3'd6, 32'h0013);
        rd_chk(3'd6, 32'h0013, "R11 lock set");
        wr(3'd6, 32'h0000);
        rd_chk(3'd6, 32'h0010, "R11 lock sticky");
        wr(3'd5, 32'h20);
        rd_chk(3'd5, 32'h21, "R12 gbl frozen");
        wr(3'd5, 32'h00);
        rd_chk(3'd5, 32'h01, "R12 other bits writable");
        send_cmd(8'h55, 2'd1, 4'b0000, "R3 gated after clear");

        // R13 reset lifts freezes
        do_reset();
        #1;
        check("R13 sci_en", 32'(sci_en), 32'h0);
        rd_chk(3'd6, 32'h0, "R13 lock cleared");
        rd_chk(3'd4, 32'h0, "R13 accept cleared");
        rd_chk(3'd2, 32'h0, "R13 req cleared");
        wr(3'd5, 32'h20);
        rd_chk(3'd5, 32'h20, "R13 gbl writable");
        send_cmd(8'h55, 2'd3, 4'b1000, "R13 R1 unicast after reset");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule